// File: doc/BRIEF.md
# Time-Locked Periodic Wave Generator

This block drives a square wave whose start is tied to a shared 64-bit nanosecond time base. Software loads a 64-bit start time, a period counted in reference-clock cycles, a control word and a 42-bit trim interval. It does this through a small write-only register port. Once the time base reaches the start time, the output begins a square wave of the programmed period. The high phase always comes first.

A trim stage lets the wave follow a time base that is itself being rate-corrected. After each trim interval of running cycles, the next period is made one cycle longer or one cycle shorter. A control bit picks which. A period register of zero stops the wave and drops the arming. A typical use is a once-per-second marker: the period is one second's worth of reference cycles and the start time is a whole second.

Control is a three-state machine:
- ST_IDLE: stopped.
- ST_WAIT: armed, waiting for the start time.
- ST_RUN: wave running.

Its transitions are:
- ENABLE: ST_IDLE to ST_WAIT, taken when the stored period is non-zero.
- ARM: ST_WAIT to ST_RUN, taken when the time base is greater than or equal to the start time.
- DISABLE: any state to ST_IDLE, taken when a zero period is written.

Top module: `timed_wave_gen`

## Requirements
- R1: A synchronous active-high reset clears every register, puts the machine in ST_IDLE and drives `wave_out` low.
- R2: A write with `wr_en` high updates the addressed register at that clock edge. The address map is:
  - 0: start time bits 31:0
  - 1: start time bits 63:32
  - 2: period
  - 3: control, where bit 1 is the trim direction
  - 4: trim interval bits 31:0
  - 5: trim interval bits 41:32, taken from `wr_data[9:0]`
- R3: A write of zero to the period register (DISABLE) puts the machine in ST_IDLE at that edge, from any state. `wave_out` is then low until the block is enabled and armed again.
- R4: In ST_IDLE, a non-zero stored period moves the machine to ST_WAIT at the next edge (ENABLE). `wave_out` stays low in ST_IDLE and ST_WAIT.
- R5: In ST_WAIT, the machine moves to ST_RUN at the first edge where the time base is greater than or equal to the 64-bit start time. Equality counts. `wave_out` is high in the first ST_RUN cycle. While the time base is below the start time, the machine stays in ST_WAIT.
- R6: In ST_RUN, a period of P cycles consists of ceil(P/2) high cycles followed by floor(P/2) low cycles, repeating. With P = 1 the output stays high.
- R7: A trim interval of zero applies no correction, so every period is exactly P cycles.
- R8: With a non-zero trim interval T, one correction becomes pending every T cycles spent in ST_RUN. The ST_RUN cycle count starts at zero on ARM. The pending correction is applied to the period that begins after the next period boundary. That period is P+1 cycles when control bit 1 is 1, and P-1 cycles when it is 0. A P of 1 is not shortened.
- R9: Re-enabling after DISABLE restarts the wave from the start of a high phase, with the trim count cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| time_ns | input | 64 | Shared nanosecond time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| wave_out | output | 1 | Periodic output |

## Verification
A corrupted machine state shows at the port within one cycle. A stray ST_RUN drives `wave_out` high while the block should be stopped. A missed ARM keeps the output low past the cycle after the start time is reached.

A phase counter that is off by one, or a lost period reload, changes the spacing of rising edges within the first one or two periods. A fault in the trim stage stays hidden until the first trim interval expires. It then appears as a wrong edge spacing at the next period boundary. For that reason, rising-edge spacings are recorded over ten periods.

// File: rtl/twg_pkg.sv
package twg_pkg;

    localparam int TWG_ADDR_W = 3;

    localparam logic [TWG_ADDR_W-1:0] ADR_START_LO = 3'd0;
    localparam logic [TWG_ADDR_W-1:0] ADR_START_HI = 3'd1;
    localparam logic [TWG_ADDR_W-1:0] ADR_PERIOD   = 3'd2;
    localparam logic [TWG_ADDR_W-1:0] ADR_CTRL     = 3'd3;
    localparam logic [TWG_ADDR_W-1:0] ADR_TRIM_LO  = 3'd4;
    localparam logic [TWG_ADDR_W-1:0] ADR_TRIM_HI  = 3'd5;

    // Bit of the control word that picks lengthen (1) or shorten (0).
    localparam int CTRL_DIR_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } twg_state_e;

endpackage

// File: rtl/twg_regs.sv
module twg_regs
    import twg_pkg::*;
#(
    parameter int TIME_W   = 64,
    parameter int PERIOD_W = 32,
    parameter int TRIM_W   = 42,
    parameter int DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [TWG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [TIME_W-1:0]     start_q,
    output logic [PERIOD_W-1:0]   period_q,
    output logic [TRIM_W-1:0]     trim_q,
    output logic                  lengthen_q,
    output logic                  zero_wr
);

    localparam int START_HI_W = TIME_W - DATA_W;
    localparam int TRIM_HI_W  = TRIM_W - DATA_W;

    assign zero_wr = wr_en && (wr_addr == ADR_PERIOD)
                     && (wr_data[PERIOD_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= '0;
            period_q   <= '0;
            trim_q     <= '0;
            lengthen_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_START_LO: start_q[DATA_W-1:0]      <= wr_data;
                ADR_START_HI: start_q[TIME_W-1:DATA_W] <= wr_data[START_HI_W-1:0];
                ADR_PERIOD:   period_q                 <= wr_data[PERIOD_W-1:0];
                ADR_CTRL:     lengthen_q               <= wr_data[CTRL_DIR_BIT];
                ADR_TRIM_LO:  trim_q[DATA_W-1:0]       <= wr_data;
                ADR_TRIM_HI:  trim_q[TRIM_W-1:DATA_W]  <= wr_data[TRIM_HI_W-1:0];
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/twg_trim.sv
module twg_trim #(
    parameter int TRIM_W = 42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [TRIM_W-1:0] trim_len,
    input  logic              take,
    output logic              pend
);

    logic [TRIM_W-1:0] tcnt_q;
    logic              hit;

    assign hit = (trim_len != '0) && (tcnt_q == trim_len - TRIM_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            tcnt_q <= '0;
            pend   <= 1'b0;
        end else if (hit) begin
            tcnt_q <= '0;
            pend   <= 1'b1;
        end else begin
            tcnt_q <= (trim_len == '0) ? '0 : tcnt_q + TRIM_W'(1);
            if (take) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twg_phase.sv
module twg_phase #(
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                active,
    input  logic                pend,
    input  logic                lengthen,
    input  logic [PERIOD_W-1:0] period,
    output logic                take,
    output logic                wave_hi,
    output logic [PERIOD_W:0]   cnt_o,
    output logic [PERIOD_W:0]   len_o
);

    localparam int LEN_W = PERIOD_W + 1;

    logic [LEN_W-1:0] cnt_q, len_q, per_ext, next_len, hi_len;
    logic             wrap;

    assign per_ext = {1'b0, period};

    always_comb begin
        wrap = active && ((cnt_q + LEN_W'(1)) >= len_q);
        take = wrap && pend;
        if (pend && lengthen) begin
            next_len = per_ext + LEN_W'(1);
        end else if (pend && (per_ext > LEN_W'(1))) begin
            next_len = per_ext - LEN_W'(1);
        end else begin
            next_len = per_ext;
        end
        hi_len  = (len_q + LEN_W'(1)) >> 1;
        wave_hi = cnt_q < hi_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            len_q <= per_ext;
        end else if (wrap) begin
            cnt_q <= '0;
            len_q <= next_len;
        end else if (active) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign len_o = len_q;

endmodule

// File: rtl/timed_wave_gen.sv
module timed_wave_gen
    import twg_pkg::*;
#(
    parameter int TIME_W   = 64,
    parameter int PERIOD_W = 32,
    parameter int TRIM_W   = 42,
    parameter int DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TIME_W-1:0]     time_ns,
    input  logic                  wr_en,
    input  logic [TWG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  wave_out
);

    twg_state_e          state, state_nx;
    logic [TIME_W-1:0]   start_q;
    logic [PERIOD_W-1:0] period_q;
    logic [TRIM_W-1:0]   trim_q;
    logic                lengthen_q, zero_wr;
    logic                run_start, running, pend, take, wave_hi;
    logic [PERIOD_W:0]   phase_cnt, phase_len;

    twg_regs #(
        .TIME_W(TIME_W), .PERIOD_W(PERIOD_W), .TRIM_W(TRIM_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start_q(start_q), .period_q(period_q), .trim_q(trim_q),
        .lengthen_q(lengthen_q), .zero_wr(zero_wr)
    );

    // ENABLE / ARM / DISABLE transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (period_q != '0)      state_nx = ST_WAIT;
            ST_WAIT: if (time_ns >= start_q)  state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
        if (zero_wr) begin
            state_nx = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign running   = (state == ST_RUN);
    assign run_start = (state == ST_WAIT) && (state_nx == ST_RUN);

    twg_trim #(.TRIM_W(TRIM_W)) u_trim (
        .clk(clk), .rst(rst), .active(running), .trim_len(trim_q),
        .take(take), .pend(pend)
    );

    twg_phase #(.PERIOD_W(PERIOD_W)) u_phase (
        .clk(clk), .rst(rst), .load(run_start), .active(running), .pend(pend),
        .lengthen(lengthen_q), .period(period_q), .take(take),
        .wave_hi(wave_hi), .cnt_o(phase_cnt), .len_o(phase_len)
    );

    always_comb begin
        wave_out = running && wave_hi;
    end

endmodule

// File: rtl/twg_checker.sv
module twg_checker
    import twg_pkg::*;
#(
    parameter int TIME_W   = 64,
    parameter int PERIOD_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [TIME_W-1:0]   time_ns,
    input logic [TIME_W-1:0]   start_q,
    input logic [PERIOD_W-1:0] period_q,
    input twg_state_e          state,
    input logic                zero_wr,
    input logic                wave_out,
    input logic [PERIOD_W:0]   phase_cnt,
    input logic [PERIOD_W:0]   phase_len
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!wave_out && state == ST_IDLE));

    assert_zero_period_R3: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> (state == ST_IDLE && !wave_out));

    assert_stopped_low_R4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> !wave_out);

    assert_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && period_q != '0 && !zero_wr) |=> (state == ST_WAIT));

    assert_arm_high_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && time_ns >= start_q && !zero_wr) |=> wave_out);

    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && time_ns < start_q) |=> (state != ST_RUN));

    assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (phase_cnt < phase_len));

endmodule

bind timed_wave_gen twg_checker #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W)) u_chk (
    .clk(clk), .rst(rst), .time_ns(time_ns), .start_q(start_q),
    .period_q(period_q), .state(state), .zero_wr(zero_wr),
    .wave_out(wave_out), .phase_cnt(phase_cnt), .phase_len(phase_len)
);

// File: tb/timed_wave_gen_tb.sv
module timed_wave_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tb_time = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wave_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timed_wave_gen u_dut (
        .clk(clk), .rst(rst), .time_ns(tb_time), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wave_out(wave_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write a period with the time base already at or past the start time.
    // Returns at the first ST_RUN cycle.
    task automatic arm_now(input int p);
        wr(3'd2, p);
        chk(wave_out == 1'b0, "R4 low after period write", wave_out, 0);
        @(negedge clk);
        chk(wave_out == 1'b0, "R4 low in wait", wave_out, 0);
        @(negedge clk);
    endtask

    task automatic t_pattern(input int p, input int n, input string req);
        arm_now(p);
        for (int i = 0; i < n; i++) begin
            bit e;
            e = (i % p) < ((p + 1) / 2);
            chk(wave_out == e, req, wave_out, e);
            if (i < n - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(wave_out == 1'b0, "R1 reset output low", wave_out, 0);
        end
    endtask

    task automatic t_arm();
        wr(3'd0, 32'd1000);
        tb_time = 64'd990;
        wr(3'd2, 32'd4);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(wave_out == 1'b0, "R5 hold below start", wave_out, 0);
        end
        tb_time = 64'd999;
        @(negedge clk);
        chk(wave_out == 1'b0, "R5 one below start", wave_out, 0);
        tb_time = 64'd1000;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            bit e;
            e = (i % 4) < 2;
            chk(wave_out == e, "R5 R6 R7 arm at equal, P=4", wave_out, e);
            if (i < 7) @(negedge clk);
        end
    endtask

    task automatic t_disable();
        wr(3'd2, 32'd0);
        chk(wave_out == 1'b0, "R3 low after zero period", wave_out, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(wave_out == 1'b0, "R3 stays low", wave_out, 0);
        end
    endtask

    task automatic t_start_hi();
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd1);
        tb_time = 64'd1000;
        wr(3'd2, 32'd4);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(wave_out == 1'b0, "R2 start high word holds wait", wave_out, 0);
        end
        tb_time = 64'h0000_0001_0000_0000;
        @(negedge clk);
        chk(wave_out == 1'b1, "R2 R5 arm on high word", wave_out, 1);
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd0);
    endtask

    task automatic t_restart();
        t_pattern(6, 4, "R6 P=6 first run");
        wr(3'd2, 32'd0);
        chk(wave_out == 1'b0, "R3 stop mid run", wave_out, 0);
        t_pattern(6, 12, "R9 restart from high phase");
        wr(3'd2, 32'd0);
    endtask

    task automatic t_trim(input bit lengthen, input logic [31:0] hi, input int exp_iv[9], input string req);
        int rises[10];
        int nr;
        bit prev;
        wr(3'd3, lengthen ? 32'h2 : 32'h0);
        wr(3'd4, 32'd25);
        wr(3'd5, hi);
        arm_now(10);
        nr = 0;
        prev = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (wave_out && !prev && nr < 10) begin
                rises[nr] = i;
                nr++;
            end
            prev = wave_out;
            @(negedge clk);
        end
        chk(nr == 10, {req, " rise count"}, nr, 10);
        for (int k = 0; k < 9; k++) begin
            int iv;
            iv = (k + 1 < nr) ? rises[k+1] - rises[k] : -1;
            chk(iv == exp_iv[k], req, iv, exp_iv[k]);
        end
        wr(3'd2, 32'd0);
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd0);
    endtask

    initial begin
        int lng[9] = '{10, 10, 10, 11, 10, 11, 10, 10, 11};
        int sht[9] = '{10, 10, 10, 9, 10, 10, 9, 10, 9};
        int flat[9] = '{10, 10, 10, 10, 10, 10, 10, 10, 10};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_arm();
        t_disable();
        t_start_hi();
        t_pattern(3, 9, "R6 odd period P=3");
        wr(3'd2, 32'd0);
        t_pattern(1, 6, "R6 P=1 constant high");
        wr(3'd2, 32'd0);
        t_restart();
        t_trim(1'b1, 32'd0, lng, "R8 lengthen");
        t_trim(1'b0, 32'd0, sht, "R8 shorten");
        t_trim(1'b1, 32'd1, flat, "R2 R7 trim high word");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule